// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 64-bit virtual address into a 48-bit physical address for a 64KB page granule, walking two levels of translation tables held in memory. The top bits of the virtual address pick one of two table base registers. The walker then fetches one 64-bit descriptor per level through a single-outstanding memory read port, and checks each descriptor for validity and write permission. It returns either the physical address or a fault together with the level at which the walk stopped.

Requests enter on a valid/ready port. `req_ready` is high only while the walker is idle, so only one walk is in flight at a time. The result is offered on a valid/ready port and held unchanged until the consumer takes it, so back-pressure from the consumer stalls the walker. On the memory side, the read request is held until the memory accepts it. The walker raises `mem_rsp_ready` in the cycles in which it waits for a descriptor. The base registers are plain control inputs, sampled while a walk runs.

Top module: `pt_walker`

## Requirements
- R1: When VA[63:42] are all zero, the first-level table base is `base0_i`.
- R2: When VA[63:42] are all one, the first-level table base is `base1_i`.
- R3: When VA[63:42] are mixed, the walk ends with `rsp_fault`=1 and `rsp_level`=0, and no memory request is issued.
- R4: The first-level read address is the selected base plus VA[41:29] times 8, as a 48-bit sum.
- R5: The second-level read address is {first-level descriptor[47:16], 16'h0} plus VA[28:16] times 8.
- R6: A descriptor is accepted only if bit 0 (valid) and bit 1 (table/page) are both 1. Otherwise the walk faults at that level, with `rsp_level`=1 for the first level and 2 for the second, and issues no further read.
- R7: A write request (`req_write`=1) faults at a level whose descriptor has bit 6 (write allowed) clear. A read ignores bit 6.
- R8: On success, `rsp_fault`=0, `rsp_level`=0 and `rsp_pa` = {second-level descriptor[47:16], VA[15:0]}. The other descriptor bits, including 63:48, have no effect.
- R9: `req_ready` is 1 only while idle. No new request is taken while a walk or a pending result exists.
- R10: `rsp_valid` and the result fields stay stable while `rsp_ready` is 0. After the handshake, `rsp_valid` drops and `req_ready` is 1 in the next cycle.
- R11: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is 1. At most one read is outstanding.
- R12: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base0_i | input | 48 | Table base used for the low region |
| base1_i | input | 48 | Table base used for the high region |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_ready | output | 1 | Walker waiting for descriptor data |
| mem_rsp_data | input | 64 | Descriptor read from memory |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 48 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_level | output | 2 | Fault level: 0 address range, 1 first table, 2 second table |

## Verification
Addresses in both the low and the high region, with distinct base registers, show whether the base is chosen from the top bits. Mixed top bits confirm that the walk stops before any memory read. Descriptors that lack the valid bit, lack the table bit, or lack write permission are placed at each level in turn. The level code and the number of reads tell apart a stop at the first table from a stop at the second. Reads and writes on the same tables separate the permission check from the validity check. Indices at their maximum, junk in the unused descriptor bits, a memory that alternately refuses requests, and a consumer that delays taking the result cover the address arithmetic, the ignored bits and both handshakes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walk_state_e;

  localparam logic [1:0] LVL_RANGE = 2'd0;
  localparam logic [1:0] LVL_ONE   = 2'd1;
  localparam logic [1:0] LVL_TWO   = 2'd2;

  localparam int DESC_VALID_BIT = 0;
  localparam int DESC_TABLE_BIT = 1;
  localparam int DESC_WRITE_BIT = 6;
endpackage

// File: rtl/ptw_region_sel.sv
module ptw_region_sel #(
  parameter int VA_W     = 64,
  parameter int PA_W     = 48,
  parameter int REGION_W = 42
) (
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] base0,
  input  logic [PA_W-1:0] base1,
  output logic            region_ok,
  output logic [PA_W-1:0] base_sel
);
  logic all_one, all_zero;

  always_comb begin
    all_one   = &va[VA_W-1:REGION_W];
    all_zero  = ~|va[VA_W-1:REGION_W];
    region_ok = all_one | all_zero;
    base_sel  = all_one ? base1 : base0;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W        = 48,
  parameter int IDX_W       = 13,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  fetch_addr
);
  localparam int PAD_W = PA_W - IDX_W - ENTRY_SHIFT;

  always_comb
    fetch_addr = tbl_base + {{PAD_W{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_desc_chk.sv
module ptw_desc_chk import ptw_pkg::*; #(
  parameter int DESC_W = 64
) (
  input  logic [DESC_W-1:0] desc,
  input  logic              is_write,
  output logic              desc_ok
);
  always_comb
    desc_ok = desc[DESC_VALID_BIT] & desc[DESC_TABLE_BIT] &
              (~is_write | desc[DESC_WRITE_BIT]);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl import ptw_pkg::*; #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 48,
  parameter int DESC_W     = 64,
  parameter int PAGE_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic [VA_W-1:0]   va_q,
  output logic              write_q,
  input  logic              region_ok,
  input  logic [PA_W-1:0]   l1_addr,
  input  logic [PA_W-1:0]   l2_addr,
  output logic [PA_W-1:0]   tbl_base_q,
  input  logic              desc_ok,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_fault,
  output logic [1:0]        rsp_level
);
  walk_state_e state_q;

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_req_valid = ((state_q == ST_L1_REQ) && region_ok) || (state_q == ST_L2_REQ);
    mem_req_addr  = (state_q == ST_L2_REQ) ? l2_addr : l1_addr;
    mem_rsp_ready = (state_q == ST_L1_WAIT) || (state_q == ST_L2_WAIT);
    rsp_valid     = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      write_q    <= 1'b0;
      tbl_base_q <= '0;
      rsp_pa     <= '0;
      rsp_fault  <= 1'b0;
      rsp_level  <= LVL_RANGE;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          write_q <= req_write;
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: begin
          if (!region_ok) begin
            rsp_pa    <= '0;
            rsp_fault <= 1'b1;
            rsp_level <= LVL_RANGE;
            state_q   <= ST_DONE;
          end else if (mem_req_ready) begin
            state_q <= ST_L1_WAIT;
          end
        end
        ST_L1_WAIT: if (mem_rsp_valid) begin
          if (desc_ok) begin
            tbl_base_q <= {mem_rsp_data[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            state_q    <= ST_L2_REQ;
          end else begin
            rsp_pa    <= '0;
            rsp_fault <= 1'b1;
            rsp_level <= LVL_ONE;
            state_q   <= ST_DONE;
          end
        end
        ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          if (desc_ok) begin
            rsp_pa    <= {mem_rsp_data[PA_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT-1:0]};
            rsp_fault <= 1'b0;
            rsp_level <= LVL_RANGE;
          end else begin
            rsp_pa    <= '0;
            rsp_fault <= 1'b1;
            rsp_level <= LVL_TWO;
          end
          state_q <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 48,
  parameter int DESC_W     = 64,
  parameter int PAGE_SHIFT = 16,
  parameter int IDX_W      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   base0_i,
  input  logic [PA_W-1:0]   base1_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_fault,
  output logic [1:0]        rsp_level
);
  localparam int LEVELS      = 2;
  localparam int REGION_W    = PAGE_SHIFT + LEVELS * IDX_W;
  localparam int ENTRY_SHIFT = $clog2(DESC_W / 8);

  logic [VA_W-1:0] va_q;
  logic            write_q;
  logic            region_ok;
  logic [PA_W-1:0] sel_base;
  logic [PA_W-1:0] tbl_base_q;
  logic            desc_ok;
  logic [PA_W-1:0] lvl_base [LEVELS];
  logic [PA_W-1:0] lvl_addr [LEVELS];

  ptw_region_sel #(.VA_W(VA_W), .PA_W(PA_W), .REGION_W(REGION_W)) u_region (
    .va(va_q), .base0(base0_i), .base1(base1_i),
    .region_ok(region_ok), .base_sel(sel_base)
  );

  assign lvl_base[0] = sel_base;
  assign lvl_base[1] = tbl_base_q;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int IDX_HI = PAGE_SHIFT + IDX_W * (LEVELS - lv) - 1;
    ptw_addr_gen #(.PA_W(PA_W), .IDX_W(IDX_W), .ENTRY_SHIFT(ENTRY_SHIFT)) u_addr (
      .tbl_base(lvl_base[lv]),
      .idx(va_q[IDX_HI -: IDX_W]),
      .fetch_addr(lvl_addr[lv])
    );
  end

  ptw_desc_chk #(.DESC_W(DESC_W)) u_chk (
    .desc(mem_rsp_data), .is_write(write_q), .desc_ok(desc_ok)
  );

  ptw_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W), .PAGE_SHIFT(PAGE_SHIFT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
    .va_q(va_q), .write_q(write_q), .region_ok(region_ok),
    .l1_addr(lvl_addr[0]), .l2_addr(lvl_addr[1]), .tbl_base_q(tbl_base_q),
    .desc_ok(desc_ok),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 48,
  parameter int DESC_W     = 64,
  parameter int PAGE_SHIFT = 16,
  parameter int IDX_W      = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_va,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_pa,
  input logic              rsp_fault,
  input logic [1:0]        rsp_level
);
  localparam int REGION_W = PAGE_SHIFT + 2 * IDX_W;

  logic [VA_W-1:0] cap_va;
  logic            busy;
  logic            cap_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_va <= '0;
      busy   <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_va <= req_va;
      busy   <= 1'b1;
    end else if (rsp_valid && rsp_ready) begin
      busy <= 1'b0;
    end
  end

  assign cap_bad = ~(&cap_va[VA_W-1:REGION_W]) & (|cap_va[VA_W-1:REGION_W]);

  AST_BADVA_NOFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cap_bad |-> !mem_req_valid);  // R3
  AST_BADVA_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && busy && cap_bad |-> rsp_fault && rsp_level == 2'd0);  // R3
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_pa[PAGE_SHIFT-1:0] == cap_va[PAGE_SHIFT-1:0]);  // R8
  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid && !busy);  // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_level));  // R10
  AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !rsp_valid && req_ready);  // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));  // R11
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)
) u_walker_chk (.*);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] base0_i = 48'h0000_1234_0000;
  logic [47:0] base1_i = 48'h0000_5678_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [47:0] rsp_pa;
  logic        rsp_fault;
  logic [1:0]  rsp_level;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int fetch_cnt = 0;
  logic [47:0] fetch_addr [4];
  logic [63:0] mem_model [logic [47:0]];
  logic [47:0] got_pa;
  logic        got_fault;
  logic [1:0]  got_level;

  always #2 clk = ~clk;

  pt_walker uut (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder: one outstanding read, data one cycle after acceptance
  initial begin
    bit pending = 0;
    bit held = 0;
    logic [47:0] paddr = '0;
    logic [47:0] haddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (held) begin
        check(mem_req_valid && mem_req_addr == haddr, "R11 request held", {16'h0, mem_req_addr}, {16'h0, haddr});
        held = 0;
      end
      mem_req_ready = stall_mode ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        if (fetch_cnt < 4) fetch_addr[fetch_cnt] = mem_req_addr;
        fetch_cnt++;
        pending = 1;
        paddr = mem_req_addr;
      end else begin
        if (mem_req_valid) begin
          held = 1;
          haddr = mem_req_addr;
        end
        if (pending) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_model.exists(paddr) ? mem_model[paddr] : 64'h0;
          pending = 0;
        end
      end
    end
  end

  task automatic walk(input logic [63:0] va, input logic wr, input int hold);
    fetch_cnt = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got_pa = rsp_pa; got_fault = rsp_fault; got_level = rsp_level;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_pa == got_pa && rsp_fault == got_fault && rsp_level == got_level,
            "R10 result held", {15'h0, rsp_valid, rsp_pa}, {16'h0001, got_pa});
      check(!req_ready, "R9 busy while result pending", {63'h0, req_ready}, 64'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R10 release to idle", {62'h0, rsp_valid, req_ready}, 64'h1);
  endtask

  // Build tables for one VA, returning the expected addresses and PA
  task automatic build(input logic [63:0] va, input logic [47:0] base, input logic [15:0] l1lo,
                       input logic [15:0] l2lo, input logic [47:0] l2tbl, input logic [47:0] page,
                       output logic [47:0] l1a, output logic [47:0] l2a, output logic [47:0] pa);
    mem_model.delete();
    l1a = base + {32'h0, va[41:29], 3'b000};
    l2a = {l2tbl[47:16], 16'h0} + {32'h0, va[28:16], 3'b000};
    mem_model[l1a] = {16'hABCD, l2tbl[47:16], l1lo};
    mem_model[l2a] = {16'h5A5A, page[47:16], l2lo};
    pa = {page[47:16], va[15:0]};
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R12 req_ready after reset", {63'h0, req_ready}, 64'h1);
    check(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R12 outputs idle after reset",
          {62'h0, rsp_valid, mem_req_valid}, 64'h0);
  endtask

  task automatic t_low_read;
    logic [63:0] va = 64'h0000_0123_4567_89AB;
    logic [47:0] l1a, l2a, pa;
    build(va, base0_i, 16'h0043, 16'hF7C3, 48'h0002_0003_0000, 48'h0000_BEEF_0000, l1a, l2a, pa);
    walk(va, 1'b0, 0);
    check(fetch_cnt == 2, "R1 two reads", fetch_cnt, 2);
    check(fetch_addr[0] == l1a, "R1 R4 level-1 address from base0", {16'h0, fetch_addr[0]}, {16'h0, l1a});
    check(fetch_addr[1] == l2a, "R5 level-2 address", {16'h0, fetch_addr[1]}, {16'h0, l2a});
    check(!got_fault && got_level == 2'd0 && got_pa == pa, "R8 physical address",
          {14'h0, got_level, got_pa}, {16'h0, pa});
  endtask

  task automatic t_high_write;
    logic [63:0] va = 64'hFFFF_FD55_AAAA_1357;
    logic [47:0] l1a, l2a, pa;
    build(va, base1_i, 16'h0043, 16'h0047, 48'h0007_7777_0000, 48'h8000_0001_0000, l1a, l2a, pa);
    walk(va, 1'b1, 0);
    check(fetch_addr[0] == l1a, "R2 level-1 address from base1", {16'h0, fetch_addr[0]}, {16'h0, l1a});
    check(!got_fault && got_pa == pa, "R2 R7 write with permission", {15'h0, got_fault, got_pa}, {16'h0, pa});
  endtask

  task automatic t_bad_region;
    walk(64'h8000_0000_0000_0000, 1'b0, 0);
    check(got_fault && got_level == 2'd0, "R3 mixed top bits fault", {62'h0, got_level}, 64'h0);
    check(fetch_cnt == 0, "R3 no memory read", fetch_cnt, 0);
    walk(64'h0000_0400_0000_0000, 1'b0, 0);
    check(got_fault && got_level == 2'd0 && fetch_cnt == 0, "R3 only bit 42 set",
          {61'h0, got_fault, got_level}, 64'h4);
  endtask

  task automatic t_l1_bad;
    logic [63:0] va = 64'h0000_0001_0002_0003;
    logic [47:0] l1a, l2a, pa;
    build(va, base0_i, 16'h0042, 16'h0043, 48'h0001_0000_0000, 48'h0000_1111_0000, l1a, l2a, pa);
    walk(va, 1'b0, 0);
    check(got_fault && got_level == 2'd1 && fetch_cnt == 1, "R6 level-1 valid bit clear",
          {got_fault, got_level, 61'(fetch_cnt)}, 64'h0);
    build(va, base0_i, 16'h0041, 16'h0043, 48'h0001_0000_0000, 48'h0000_1111_0000, l1a, l2a, pa);
    walk(va, 1'b0, 0);
    check(got_fault && got_level == 2'd1 && fetch_cnt == 1, "R6 level-1 table bit clear",
          {62'h0, got_level}, 64'h1);
  endtask

  task automatic t_l2_bad;
    logic [63:0] va = 64'h0000_0002_0004_0006;
    logic [47:0] l1a, l2a, pa;
    build(va, base0_i, 16'h0043, 16'h0040, 48'h0003_0000_0000, 48'h0000_2222_0000, l1a, l2a, pa);
    walk(va, 1'b0, 0);
    check(got_fault && got_level == 2'd2 && fetch_cnt == 2, "R6 level-2 invalid",
          {62'h0, got_level}, 64'h2);
    check(got_pa == 48'h0, "R6 fault clears pa", {16'h0, got_pa}, 64'h0);
  endtask

  task automatic t_perm;
    logic [63:0] va = 64'h0000_0003_0005_0007;
    logic [47:0] l1a, l2a, pa;
    build(va, base0_i, 16'h0003, 16'h0043, 48'h0004_0000_0000, 48'h0000_3333_0000, l1a, l2a, pa);
    walk(va, 1'b1, 0);
    check(got_fault && got_level == 2'd1 && fetch_cnt == 1, "R7 write denied at level 1",
          {62'h0, got_level}, 64'h1);
    walk(va, 1'b0, 0);
    check(!got_fault && got_pa == pa, "R7 read ignores bit 6", {16'h0, got_pa}, {16'h0, pa});
    build(va, base0_i, 16'h0043, 16'hFFBF, 48'h0004_0000_0000, 48'h0000_3333_0000, l1a, l2a, pa);
    walk(va, 1'b1, 0);
    check(got_fault && got_level == 2'd2, "R7 write denied at level 2", {62'h0, got_level}, 64'h2);
  endtask

  task automatic t_max_index;
    logic [63:0] va = 64'h0000_03FF_FFFF_1234;
    logic [47:0] l1a, l2a, pa;
    build(va, base0_i, 16'hFFFF, 16'h0003, 48'hFFF0_0000_0000, 48'hFFFF_FFFF_0000, l1a, l2a, pa);
    walk(va, 1'b0, 0);
    check(fetch_addr[0] == l1a && fetch_addr[1] == l2a, "R4 R5 maximum indices",
          {16'h0, fetch_addr[1]}, {16'h0, l2a});
    check(!got_fault && got_pa == pa, "R8 maximum indices pa", {16'h0, got_pa}, {16'h0, pa});
  endtask

  task automatic t_backpressure;
    logic [63:0] va = 64'hFFFF_FC10_2030_4050;
    logic [47:0] l1a, l2a, pa;
    stall_mode = 1;
    build(va, base1_i, 16'h0043, 16'h0043, 48'h0009_0000_0000, 48'h0012_3456_0000, l1a, l2a, pa);
    walk(va, 1'b0, 3);
    check(fetch_cnt == 2 && got_pa == pa, "R11 stalled memory walk", {16'h0, got_pa}, {16'h0, pa});
    stall_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_read();
    t_high_write();
    t_bad_region();
    t_l1_bad();
    t_l2_bad();
    t_perm();
    t_max_index();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 50000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule